// File: doc/BRIEF.md
# Dual-Clock FIFO Status Flag Generator

This block produces the four status flags of a dual-clock FIFO from the Gray-coded write and read pointers, which arrive from the write-clock and read-clock domains. Empty and almost-empty are read-side flags. Full and almost-full are write-side flags. All four outputs are active low. The memory array, the pointer counters and any threshold registers are outside the block. The thresholds arrive as plain inputs.

Two choices are made once, while reset is held.

The first choice is the timing of the two partial flags:
- **Synchronous:** each partial flag is a register in its home domain. It compares the local pointer with a two-flop copy of the far pointer.
- **Asynchronous:** a flag is set by an edge of the clock of the side that drives it toward the boundary. It is cleared by an edge of the other clock. Both decisions use the raw pointers.

The second choice is the length of the synchronizer in front of the empty and full comparators. Each extra flop delays the release of that flag by one clock and reduces the risk of metastability. Only a few pairs of lengths are accepted. Any other request becomes two flops on both sides.

Top module: `fifo_flag_stage`

## Requirements
- R1: While `rst_n` is low, `empty_n`=0, `aempty_n`=0, `full_n`=1 and `afull_n`=1. These values hold after release until a pointer moves.
- R2: The mode bit and both depth requests are captured on clock edges while `rst_n` is low. Changes to those pins after release have no effect on any flag's timing.
- R3: A write is seen by the read side after the empty depth `d` (1, 2 or 3 flops). `empty_n` rises on the (d+1)-th `rclk` rising edge after `wptr_gray` changes. Likewise, `full_n` rises on the (d+1)-th `wclk` rising edge after `rptr_gray` changes, where `d` is the full depth.
- R4: Empty asserts on the first `rclk` edge at which `rptr_gray` equals the synchronized write pointer. Full asserts on the first `wclk` edge at which the write pointer is exactly 2^ADDR_W words ahead of the synchronized read pointer. This includes wrap of the binary pointer across the extra top bit.
- R5: In synchronous mode, `aempty_n` is 0 exactly when the fill level, computed as a 2-flop-synchronized write pointer minus the read pointer, is ≤ `ae_level`. The flag is updated only on `rclk`, so a write that lifts the fill level above the threshold releases it on the 3rd `rclk` edge.
- R6: In synchronous mode, `afull_n` is 0 exactly when the fill level, computed as the write pointer minus a 2-flop-synchronized read pointer, is ≥ 2^ADDR_W − `af_level`. The flag is updated only on `wclk`, so a read that lowers the fill level below the threshold releases it on the 3rd `wclk` edge.
- R7: In asynchronous mode, `aempty_n` falls on the first `rclk` edge at which the raw fill level is ≤ `ae_level`. It rises on the first `wclk` edge at which the raw fill level is above it.
- R8: In asynchronous mode, `afull_n` falls on the first `wclk` edge at which the raw fill level is ≥ 2^ADDR_W − `af_level`. It rises on the first `rclk` edge at which the raw fill level is below that value.
- R9: Depth codes 1, 2 and 3 mean that many flops. The accepted (empty, full) pairs are (1,1), (2,2), (3,3), (1,2) and (2,1). Every other pair, including any code 0, runs as (2,2).
- R10: The partial flags keep the latencies of R5 to R8 whatever depths are chosen for empty and full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset; also the configuration window |
| cfg_pf_async | input | 1 | 1 selects asynchronous partial-flag timing |
| cfg_empty_depth | input | 2 | Requested synchronizer length for the empty flag |
| cfg_full_depth | input | 2 | Requested synchronizer length for the full flag |
| wptr_gray | input | ADDR_W+1 | Write pointer, Gray code, write domain |
| rptr_gray | input | ADDR_W+1 | Read pointer, Gray code, read domain |
| ae_level | input | ADDR_W+1 | Almost-empty threshold in words |
| af_level | input | ADDR_W+1 | Almost-full threshold in free words |
| empty_n | output | 1 | Empty, active low, read domain |
| full_n | output | 1 | Full, active low, write domain |
| aempty_n | output | 1 | Almost empty, active low |
| afull_n | output | 1 | Almost full, active low |

## Verification
Each flag has a different due cycle after a pointer move:
- A move of the local pointer shows on the next local edge.
- A move of the far pointer reaches empty or full after depth+1 local edges.
- It reaches a synchronous partial flag after three local edges.
- It reaches an asynchronous partial flag on the very next edge of the clearing or setting clock.

The bench moves pointers on a falling edge of the clock whose count matters. It samples one falling edge after the due rising edge. Where the latency itself is the point, it also samples one edge earlier, so an extra or missing flop is caught. Before each move it waits long enough for earlier moves to settle through every synchronizer.

// File: rtl/ffs_pkg.sv
package ffs_pkg;

  typedef struct packed {
    logic       pf_async;
    logic [1:0] e_depth;
    logic [1:0] f_depth;
  } ffs_cfg_t;

  // True for the depth pairs the flag stage accepts.
  function automatic logic combo_ok(input logic [1:0] e, input logic [1:0] f);
    return ((e == f) && (e != 2'd0)) ||
           ((e == 2'd1) && (f == 2'd2)) ||
           ((e == 2'd2) && (f == 2'd1));
  endfunction

  // Map a raw request onto a supported configuration.
  function automatic ffs_cfg_t legalize(input logic a, input logic [1:0] e,
                                        input logic [1:0] f);
    ffs_cfg_t c;
    c.pf_async = a;
    if (combo_ok(e, f)) begin
      c.e_depth = e;
      c.f_depth = f;
    end else begin
      c.e_depth = 2'd2;
      c.f_depth = 2'd2;
    end
    return c;
  endfunction

endpackage

// File: rtl/ffs_cfg_latch.sv
module ffs_cfg_latch #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req,
  output logic [W-1:0] held
);

  // Loads only while reset is low; frozen afterwards.
  always_ff @(posedge clk) begin
    if (!rst_n) held <= req;
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(held)); // R2

endmodule

// File: rtl/ffs_sync.sv
module ffs_sync #(
  parameter int W      = 5,
  parameter int MAX_ST = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   sel,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st [MAX_ST];

  generate
    for (genvar g = 0; g < MAX_ST; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st[0] <= '0;
          else        st[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st[g] <= '0;
          else        st[g] <= st[g-1];
        end
      end
    end
  endgenerate

  // Tap after 'sel' flops; anything out of range uses the first flop.
  always_comb begin
    q = st[0];
    for (int i = 0; i < MAX_ST; i++) begin
      if (int'(sel) == i + 1) q = st[i];
    end
  end

endmodule

// File: rtl/ffs_edge_flag.sv
module ffs_edge_flag #(
  parameter int W       = 5,
  parameter bit IS_FULL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] near_gray,
  input  logic [W-1:0] far_gray,
  output logic         flag_n
);

  // Empty: pointers equal. Full: top two Gray bits inverted, rest equal.
  function automatic logic meet(input logic [W-1:0] nr, input logic [W-1:0] fr);
    if (IS_FULL) return nr == {~fr[W-1:W-2], fr[W-3:0]};
    else         return nr == fr;
  endfunction

  logic boundary;
  assign boundary = meet(near_gray, far_gray);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_n <= IS_FULL;
    else        flag_n <= !boundary;
  end

  AST_FLAG_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $stable(near_gray) && $stable(far_gray) |=> $stable(flag_n)); // R3

endmodule

// File: rtl/ffs_part_flag.sv
module ffs_part_flag #(
  parameter int W       = 5,
  parameter bit IS_FULL = 1'b0
) (
  input  logic         home_clk,
  input  logic         away_clk,
  input  logic         rst_n,
  input  logic         async_mode,
  input  logic [W-1:0] home_gray,
  input  logic [W-1:0] far_gray,
  input  logic [W-1:0] level,
  output logic         flag_n
);

  localparam logic [W-1:0] DEPTH   = {1'b1, {(W-1){1'b0}}};
  localparam bit           RST_ACT = !IS_FULL;

  function automatic logic [W-1:0] g2b(input logic [W-1:0] g);
    logic [W-1:0] b;
    b[W-1] = g[W-1];
    for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Words held, from the home and far pointer views.
  function automatic logic [W-1:0] fill(input logic [W-1:0] hb, input logic [W-1:0] fb);
    if (IS_FULL) return hb - fb;
    else         return fb - hb;
  endfunction

  function automatic logic near_edge(input logic [W-1:0] cnt, input logic [W-1:0] lv);
    if (IS_FULL) return cnt >= (DEPTH - lv);
    else         return cnt <= lv;
  endfunction

  logic [W-1:0] far_s;
  logic         raw_hit, sync_hit;
  logic         set_t, clr_t, active, sync_q;

  ffs_sync #(.W(W), .MAX_ST(2)) u_far_sync (
    .clk(home_clk), .rst_n(rst_n), .sel(2'd2), .d(far_gray), .q(far_s)
  );

  assign raw_hit  = near_edge(fill(g2b(home_gray), g2b(far_gray)), level);
  assign sync_hit = near_edge(fill(g2b(home_gray), g2b(far_s)), level);

  // Asynchronous style: set toggles on the home clock, clear toggles on the other.
  assign active = set_t ^ clr_t ^ RST_ACT;

  always_ff @(posedge home_clk or negedge rst_n) begin
    if (!rst_n)                              set_t <= 1'b0;
    else if (async_mode && !active && raw_hit) set_t <= ~set_t;
  end

  always_ff @(posedge away_clk or negedge rst_n) begin
    if (!rst_n)                              clr_t <= 1'b0;
    else if (async_mode && active && !raw_hit) clr_t <= ~clr_t;
  end

  // Synchronous style: one register on the home clock.
  always_ff @(posedge home_clk or negedge rst_n) begin
    if (!rst_n) sync_q <= RST_ACT;
    else        sync_q <= sync_hit;
  end

  assign flag_n = !(async_mode ? active : sync_q);

  AST_PF_STILL: assert property (@(posedge home_clk) disable iff (!rst_n)
    $past(rst_n) && !async_mode && $stable(home_gray) && $stable(far_s) && $stable(level)
    |=> $stable(sync_q)); // R5

endmodule

// File: rtl/fifo_flag_stage.sv
module fifo_flag_stage
  import ffs_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              cfg_pf_async,
  input  logic [1:0]        cfg_empty_depth,
  input  logic [1:0]        cfg_full_depth,
  input  logic [ADDR_W:0]   wptr_gray,
  input  logic [ADDR_W:0]   rptr_gray,
  input  logic [ADDR_W:0]   ae_level,
  input  logic [ADDR_W:0]   af_level,
  output logic              empty_n,
  output logic              full_n,
  output logic              aempty_n,
  output logic              afull_n
);

  localparam int PW = ADDR_W + 1;

  ffs_cfg_t   cfg_req;
  logic [2:0] cfg_w, cfg_r;
  logic       mode_w, mode_r;
  logic [1:0] depth_full_w, depth_empty_r;
  logic [PW-1:0] wptr_in_r, rptr_in_w;

  assign cfg_req = legalize(cfg_pf_async, cfg_empty_depth, cfg_full_depth);

  ffs_cfg_latch #(.W(3)) u_cfg_w (
    .clk(wclk), .rst_n(rst_n), .req({cfg_req.pf_async, cfg_req.f_depth}), .held(cfg_w)
  );
  ffs_cfg_latch #(.W(3)) u_cfg_r (
    .clk(rclk), .rst_n(rst_n), .req({cfg_req.pf_async, cfg_req.e_depth}), .held(cfg_r)
  );

  assign {mode_w, depth_full_w}  = cfg_w;
  assign {mode_r, depth_empty_r} = cfg_r;

  // Pointer crossings for the boundary flags.
  ffs_sync #(.W(PW), .MAX_ST(3)) u_w2r (
    .clk(rclk), .rst_n(rst_n), .sel(depth_empty_r), .d(wptr_gray), .q(wptr_in_r)
  );
  ffs_sync #(.W(PW), .MAX_ST(3)) u_r2w (
    .clk(wclk), .rst_n(rst_n), .sel(depth_full_w), .d(rptr_gray), .q(rptr_in_w)
  );

  ffs_edge_flag #(.W(PW), .IS_FULL(1'b0)) u_empty (
    .clk(rclk), .rst_n(rst_n), .near_gray(rptr_gray), .far_gray(wptr_in_r), .flag_n(empty_n)
  );
  ffs_edge_flag #(.W(PW), .IS_FULL(1'b1)) u_full (
    .clk(wclk), .rst_n(rst_n), .near_gray(wptr_gray), .far_gray(rptr_in_w), .flag_n(full_n)
  );

  ffs_part_flag #(.W(PW), .IS_FULL(1'b0)) u_aempty (
    .home_clk(rclk), .away_clk(wclk), .rst_n(rst_n), .async_mode(mode_r),
    .home_gray(rptr_gray), .far_gray(wptr_gray), .level(ae_level), .flag_n(aempty_n)
  );
  ffs_part_flag #(.W(PW), .IS_FULL(1'b1)) u_afull (
    .home_clk(wclk), .away_clk(rclk), .rst_n(rst_n), .async_mode(mode_w),
    .home_gray(wptr_gray), .far_gray(rptr_gray), .level(af_level), .flag_n(afull_n)
  );

  AST_DEPTH_PAIR: assert property (@(posedge rclk) disable iff (!rst_n)
    $past(rst_n) |-> combo_ok(depth_empty_r, depth_full_w)); // R9

  AST_MODE_AGREE: assert property (@(posedge rclk) disable iff (!rst_n)
    $past(rst_n) |-> (mode_r == mode_w)); // R2

endmodule

// File: tb/tb_fifo_flag_stage.sv
module tb_fifo_flag_stage;

  localparam int AW   = 4;
  localparam int PW   = AW + 1;
  localparam int WPER = 10;
  localparam int RHALF = 7;

  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic cfg_pf_async = 1'b0;
  logic [1:0] cfg_empty_depth = 2'd1, cfg_full_depth = 2'd1;
  logic [PW-1:0] wptr_gray = '0, rptr_gray = '0;
  logic [PW-1:0] ae_level = 5'd3, af_level = 5'd3;
  logic empty_n, full_n, aempty_n, afull_n;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(WPER/2) wclk = ~wclk;
  always #(RHALF)  rclk = ~rclk;

  fifo_flag_stage #(.ADDR_W(AW)) dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .cfg_pf_async(cfg_pf_async),
    .cfg_empty_depth(cfg_empty_depth), .cfg_full_depth(cfg_full_depth),
    .wptr_gray(wptr_gray), .rptr_gray(rptr_gray), .ae_level(ae_level), .af_level(af_level),
    .empty_n(empty_n), .full_n(full_n), .aempty_n(aempty_n), .afull_n(afull_n)
  );

  typedef struct { int idx; logic val; string tag; } item_t;
  item_t sb[$];

  function automatic logic [PW-1:0] to_gray(input int b);
    logic [PW-1:0] v;
    v = PW'(b);
    return v ^ (v >> 1);
  endfunction

  // Driver side: queue an expectation for the monitor.
  task automatic expect_flag(input int idx, input logic val, input string tag);
    item_t it;
    it.idx = idx; it.val = val; it.tag = tag;
    sb.push_back(it);
    #0;
  endtask

  // Monitor: compares each queued item against the current outputs.
  initial begin
    forever begin
      item_t it;
      logic got;
      wait (sb.size() != 0);
      it = sb.pop_front();
      case (it.idx)
        0: got = empty_n;
        1: got = full_n;
        2: got = aempty_n;
        default: got = afull_n;
      endcase
      total++;
      if (got !== it.val) begin
        bad++;
        $display("FAIL %s flag%0d got=%b exp=%b at %0t", it.tag, it.idx, got, it.val, $time);
      end
    end
  end

  task automatic wait_r(input int n);
    repeat (n) @(posedge rclk);
    @(negedge rclk);
  endtask

  task automatic wait_w(input int n);
    repeat (n) @(posedge wclk);
    @(negedge wclk);
  endtask

  task automatic settle();
    wait_w(5);
    wait_r(5);
  endtask

  task automatic start(input logic a, input logic [1:0] e, input logic [1:0] f);
    @(negedge rclk);
    rst_n = 1'b0;
    cfg_pf_async = a; cfg_empty_depth = e; cfg_full_depth = f;
    wptr_gray = '0; rptr_gray = '0;
    wait_w(3);
    wait_r(3);
    expect_flag(0, 1'b0, "R1"); expect_flag(1, 1'b1, "R1");
    expect_flag(2, 1'b0, "R1"); expect_flag(3, 1'b1, "R1");
    rst_n = 1'b1;
    settle();
    expect_flag(0, 1'b0, "R1"); expect_flag(3, 1'b1, "R1");
  endtask

  initial begin
    // Config A: synchronous partial flags, empty 1 flop, full 2 flops.
    start(1'b0, 2'd1, 2'd2);
    cfg_pf_async = 1'b1; cfg_empty_depth = 2'd3; cfg_full_depth = 2'd3; // R2: ignored now
    @(negedge rclk); wptr_gray = to_gray(1);
    wait_r(1); expect_flag(0, 1'b0, "R3 e=1 early / R2");
    wait_r(1); expect_flag(0, 1'b1, "R3 e=1 due / R2");
    settle();
    @(negedge rclk); wptr_gray = to_gray(4);
    wait_r(2); expect_flag(2, 1'b0, "R5 early");
    wait_r(1); expect_flag(2, 1'b1, "R5 due");
    settle();
    @(negedge wclk); wptr_gray = to_gray(16);
    wait_w(1); expect_flag(1, 1'b0, "R4 full"); expect_flag(3, 1'b0, "R6 set");
    settle();
    @(negedge wclk); rptr_gray = to_gray(1);
    wait_w(2); expect_flag(1, 1'b0, "R3 f=2 early / R2");
    wait_w(1); expect_flag(1, 1'b1, "R3 f=2 due");
    settle();
    @(negedge wclk); rptr_gray = to_gray(4);
    wait_w(2); expect_flag(3, 1'b0, "R6 early / R2");
    wait_w(1); expect_flag(3, 1'b1, "R6 due");
    settle();
    @(negedge rclk); rptr_gray = to_gray(16);
    wait_r(1); expect_flag(0, 1'b0, "R4 empty"); expect_flag(2, 1'b0, "R5 own ptr");

    // Config B: asynchronous partial flags, 3 flops on both.
    start(1'b1, 2'd3, 2'd3);
    @(negedge rclk); wptr_gray = to_gray(1);
    wait_r(3); expect_flag(0, 1'b0, "R3 e=3 early");
    wait_r(1); expect_flag(0, 1'b1, "R3 e=3 due");
    settle();
    @(negedge wclk); wptr_gray = to_gray(4);
    wait_w(1); expect_flag(2, 1'b1, "R7 clear on wclk / R10");
    settle();
    @(negedge rclk); rptr_gray = to_gray(1);
    wait_r(1); expect_flag(2, 1'b0, "R7 set on rclk / R10");
    settle();
    @(negedge wclk); wptr_gray = to_gray(14);
    wait_w(1); expect_flag(3, 1'b0, "R8 set on wclk");
    settle();
    @(negedge rclk); rptr_gray = to_gray(2);
    wait_r(1); expect_flag(3, 1'b1, "R8 clear on rclk");
    settle();
    @(negedge wclk); wptr_gray = to_gray(18);
    wait_w(1); expect_flag(1, 1'b0, "R4 full across wrap");
    settle();
    @(negedge wclk); rptr_gray = to_gray(3);
    wait_w(3); expect_flag(1, 1'b0, "R3 f=3 early");
    wait_w(1); expect_flag(1, 1'b1, "R3 f=3 due");

    // Config C: unsupported 3/1 request runs as 2/2.
    start(1'b0, 2'd3, 2'd1);
    @(negedge rclk); wptr_gray = to_gray(1);
    wait_r(2); expect_flag(0, 1'b0, "R9 fallback e early");
    wait_r(1); expect_flag(0, 1'b1, "R9 fallback e due");
    settle();
    @(negedge rclk); wptr_gray = to_gray(4);
    wait_r(2); expect_flag(2, 1'b0, "R10 early");
    wait_r(1); expect_flag(2, 1'b1, "R10 due");
    settle();
    @(negedge wclk); wptr_gray = to_gray(16);
    wait_w(1); expect_flag(1, 1'b0, "R4 full C");
    settle();
    @(negedge wclk); rptr_gray = to_gray(1);
    wait_w(2); expect_flag(1, 1'b0, "R9 fallback f early");
    wait_w(1); expect_flag(1, 1'b1, "R9 fallback f due");

    // Config D: supported 2/1 pair is kept.
    start(1'b0, 2'd2, 2'd1);
    @(negedge rclk); wptr_gray = to_gray(16);
    wait_r(2); expect_flag(0, 1'b0, "R9 2/1 e early");
    wait_r(1); expect_flag(0, 1'b1, "R9 2/1 e due");
    settle();
    @(negedge wclk); rptr_gray = to_gray(1);
    wait_w(1); expect_flag(1, 1'b0, "R9 2/1 f early");
    wait_w(1); expect_flag(1, 1'b1, "R9 2/1 f due");

    wait (sb.size() == 0);
    #1;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(WPER * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule